// File: doc/BRIEF.md
# Port-Driven Memory Bank Switcher

This block steers every memory access of an 8-bit CPU with a 64 KiB address space to exactly one of three targets: RAM, the boot (monitor) ROM, or the memory-mapped I/O window. When the top of the space is blanked, it steers the access to none of them. The space is split into a low region (0x0000 to 0x0FFF), a middle region (0x1000 to 0xCFFF) and a top region (0xD000 to 0xFFFF). The middle region is always RAM. The low and top regions are remapped by I/O writes to a small group of ports.

Software changes the map by executing an I/O write to one of seven consecutive port numbers starting at 0xE0. The value on the data bus plays no part, so the data bus is not an input to the block. One port blanks the top region and a companion port lifts the blanking. While the top region is blanked, the block still remembers its mapping, so lifting the blanking brings that mapping back unchanged.

Top module: `bank_switcher`

## Requirements
- R1: A port write is taken only when `iorq_n` and `wr_n` are both low and `addr[7:0]` equals a port number. The upper address byte is ignored. An I/O read, a memory write, or a write to any other port number leaves the map unchanged.
- R2: Whatever the port writes, a memory cycle in 0x1000 to 0xCFFF asserts `sel_ram`, and this holds even while the top region is blanked.
- R3: A write to port 0xE0 maps the low region (0x0000 to 0x0FFF) to RAM. A write to port 0xE2 maps it to ROM.
- R4: A write to port 0xE1 maps the top region (0xD000 to 0xFFFF) to RAM. A write to port 0xE3 maps it to I/O.
- R5: A write to port 0xE4 sets the low region to ROM and the top region to I/O in one step, and leaves the blanking flag as it was.
- R6: A write to port 0xE5 sets `top_inhibit`. While it is set, no select asserts for a top-region address. A second write to 0xE5 changes nothing further.
- R7: A write to port 0xE6 clears `top_inhibit` and restores the top mapping that was remembered. Writes to 0xE5 and 0xE6 never change the low-region mapping.
- R8: A write to 0xE1 or 0xE3 while the top region is blanked updates the remembered top mapping and keeps `top_inhibit` set.
- R9: A synchronous reset (`rst_n` low at a rising edge) sets the low region to ROM and the top region to I/O, and clears `top_inhibit`.
- R10: The selects depend combinationally on the address and strobes, and at most one of them is high. None is high unless `mreq_n` is low and `rd_n` or `wr_n` is low.
- R11: A port write changes the map at the rising edge at which the write strobe is sampled. Before that edge, the selects follow the old map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | CPU address bus; low byte carries the port number in I/O cycles |
| iorq_n | input | 1 | I/O request strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel_ram | output | 1 | RAM select for the current memory cycle |
| sel_rom | output | 1 | Monitor ROM select for the current memory cycle |
| sel_io | output | 1 | Memory-mapped I/O select for the current memory cycle |
| top_inhibit | output | 1 | High while the top region is blanked |

## Verification
The hardest state to reach from the ports is a top mapping that changes while the region is blanked and then comes back into view. The stimulus blanks the top region, writes the other top-region port, and confirms that the top region stays silent. It then lifts the blanking and expects the newly written mapping, not the mapping that held before the blank. The edge timing of a write is shown in one cycle that holds an I/O write and a memory read together, on an address whose low byte is a port number and whose high byte lies in the top region. The selects are sampled before and after the edge that takes the write.

// File: rtl/bank_switcher_pkg.sv
// Package: shared constants and types for the memory bank switcher.
// Assumes ports are consecutive from MAP_PORT_BASE; the index order below
// is behavioural (each index is tied to one map action).
package bank_switcher_pkg;

    localparam int MAP_PORT_BASE = 8'hE0;
    localparam int MAP_PORT_NUM  = 7;

    // Port index offsets from MAP_PORT_BASE.
    localparam int PIX_LOW_RAM  = 0;
    localparam int PIX_TOP_RAM  = 1;
    localparam int PIX_LOW_ROM  = 2;
    localparam int PIX_TOP_IO   = 3;
    localparam int PIX_DEFAULT  = 4;
    localparam int PIX_BLANK    = 5;
    localparam int PIX_UNBLANK  = 6;

    typedef enum logic [1:0] {
        REGION_LOW = 2'd0,
        REGION_MID = 2'd1,
        REGION_TOP = 2'd2
    } region_e;

    typedef enum logic {
        TOP_RAM = 1'b0,
        TOP_IO  = 1'b1
    } top_map_e;

endpackage

// File: rtl/bank_port_decode.sv
// Module: bank_port_decode
// Turns an I/O write cycle into a one-hot vector of port hits, one bit per
// map port. Assumes active-low strobes and that only the low address byte
// selects the port; no data bus value is consulted.
module bank_port_decode #(
    parameter int PORT_W    = 8,
    parameter int PORT_BASE = 8'hE0,
    parameter int PORT_NUM  = 7
) (
    input  logic [PORT_W-1:0]   port,
    input  logic                iorq_n,
    input  logic                wr_n,
    output logic [PORT_NUM-1:0] hit
);

    logic io_write;

    // Qualify: an I/O write needs both strobes low together.
    always_comb begin
        io_write = ~iorq_n & ~wr_n;
    end

    // One comparator per port number.
    for (genvar gi = 0; gi < PORT_NUM; gi++) begin : g_port
        localparam logic [PORT_W-1:0] PNUM = PORT_W'(PORT_BASE + gi);
        assign hit[gi] = io_write && (port == PNUM);
    end

endmodule

// File: rtl/bank_map_state.sv
// Module: bank_map_state
// Holds the mapping flags: low region ROM/RAM, remembered top mapping and
// the top-region blank flag. Assumes at most one hit bit is set per cycle.
// Reset is synchronous and active low.
module bank_map_state
    import bank_switcher_pkg::*;
#(
    parameter int PORT_NUM = MAP_PORT_NUM
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PORT_NUM-1:0] hit,
    output logic                low_is_rom,
    output top_map_e            top_map,
    output logic                top_inhibit
);

    // Low region flag: RAM on one port, ROM on two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_is_rom <= 1'b1;
        end else if (hit[PIX_LOW_RAM]) begin
            low_is_rom <= 1'b0;
        end else if (hit[PIX_LOW_ROM] || hit[PIX_DEFAULT]) begin
            low_is_rom <= 1'b1;
        end
    end

    // Remembered top mapping: kept even while the region is blanked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_map <= TOP_IO;
        end else if (hit[PIX_TOP_RAM]) begin
            top_map <= TOP_RAM;
        end else if (hit[PIX_TOP_IO] || hit[PIX_DEFAULT]) begin
            top_map <= TOP_IO;
        end
    end

    // Blank flag: set by one port, cleared by its companion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_inhibit <= 1'b0;
        end else if (hit[PIX_BLANK]) begin
            top_inhibit <= 1'b1;
        end else if (hit[PIX_UNBLANK]) begin
            top_inhibit <= 1'b0;
        end
    end

endmodule

// File: rtl/bank_region_select.sv
// Module: bank_region_select
// Combinational decode of a memory cycle into one of RAM, ROM or I/O
// selects using the current map flags. Assumes active-low strobes; a cycle
// with MREQ but neither RD nor WR (e.g. refresh) selects nothing.
module bank_region_select
    import bank_switcher_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LOW_LIMIT = 16'h0FFF,
    parameter int TOP_BASE  = 16'hD000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              low_is_rom,
    input  top_map_e          top_map,
    input  logic              top_inhibit,
    output logic              sel_ram,
    output logic              sel_rom,
    output logic              sel_io
);

    localparam logic [ADDR_W-1:0] LOW_END = ADDR_W'(LOW_LIMIT);
    localparam logic [ADDR_W-1:0] TOP_BEG = ADDR_W'(TOP_BASE);

    region_e region;
    logic    mem_cycle;

    // Classify the address into one of three regions.
    always_comb begin
        if (addr <= LOW_END) begin
            region = REGION_LOW;
        end else if (addr >= TOP_BEG) begin
            region = REGION_TOP;
        end else begin
            region = REGION_MID;
        end
    end

    // A memory cycle needs MREQ and one data strobe.
    always_comb begin
        mem_cycle = ~mreq_n & (~rd_n | ~wr_n);
    end

    // Drive exactly one select for the region, or none.
    always_comb begin
        sel_ram = 1'b0;
        sel_rom = 1'b0;
        sel_io  = 1'b0;
        if (mem_cycle) begin
            unique case (region)
                REGION_LOW: begin
                    sel_rom = low_is_rom;
                    sel_ram = ~low_is_rom;
                end
                REGION_TOP: begin
                    if (!top_inhibit) begin
                        sel_io  = (top_map == TOP_IO);
                        sel_ram = (top_map == TOP_RAM);
                    end
                end
                default: begin
                    sel_ram = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/bank_switcher.sv
// Module: bank_switcher (top)
// Memory-map controller: port writes in the I/O space update the map
// flags, and each memory cycle is steered to RAM, ROM or memory-mapped I/O.
// Assumes a 16-bit address with the port number on the low byte.
module bank_switcher
    import bank_switcher_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PORT_W    = 8,
    parameter int LOW_LIMIT = 16'h0FFF,
    parameter int TOP_BASE  = 16'hD000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              iorq_n,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              sel_ram,
    output logic              sel_rom,
    output logic              sel_io,
    output logic              top_inhibit
);

    logic [MAP_PORT_NUM-1:0] hit;
    logic                    low_is_rom;
    top_map_e                top_map;

    bank_port_decode #(
        .PORT_W    (PORT_W),
        .PORT_BASE (MAP_PORT_BASE),
        .PORT_NUM  (MAP_PORT_NUM)
    ) u_decode (
        .port   (addr[PORT_W-1:0]),
        .iorq_n (iorq_n),
        .wr_n   (wr_n),
        .hit    (hit)
    );

    bank_map_state #(
        .PORT_NUM (MAP_PORT_NUM)
    ) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .low_is_rom  (low_is_rom),
        .top_map     (top_map),
        .top_inhibit (top_inhibit)
    );

    bank_region_select #(
        .ADDR_W    (ADDR_W),
        .LOW_LIMIT (LOW_LIMIT),
        .TOP_BASE  (TOP_BASE)
    ) u_select (
        .addr        (addr),
        .mreq_n      (mreq_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .low_is_rom  (low_is_rom),
        .top_map     (top_map),
        .top_inhibit (top_inhibit),
        .sel_ram     (sel_ram),
        .sel_rom     (sel_rom),
        .sel_io      (sel_io)
    );

endmodule

// File: rtl/bank_switcher_chk.sv
// Module: bank_switcher_chk
// Property checker for bank_switcher, attached by bind below.
module bank_switcher_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        iorq_n,
    input logic        mreq_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic        sel_ram,
    input logic        sel_rom,
    input logic        sel_io,
    input logic        top_inhibit,
    input logic        low_is_rom,
    input logic        top_map
);

    logic io_wr;
    logic mem_cyc;
    logic in_top;
    logic in_mid;

    always_comb begin
        io_wr   = ~iorq_n & ~wr_n;
        mem_cyc = ~mreq_n & (~rd_n | ~wr_n);
        in_top  = addr >= 16'hD000;
        in_mid  = (addr >= 16'h1000) && (addr < 16'hD000);
    end

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ram, sel_rom, sel_io}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cyc |-> !(sel_ram || sel_rom || sel_io));

    // R2
    mid_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cyc && in_mid) |-> sel_ram);

    // R6
    blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_inhibit && in_top) |-> !(sel_ram || sel_rom || sel_io));

    // R6
    blank_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && addr[7:0] == 8'hE5) |=> top_inhibit);

    // R7
    blank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && addr[7:0] == 8'hE6) |=> !top_inhibit);

    // R7
    low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (addr[7:0] == 8'hE5 || addr[7:0] == 8'hE6)) |=> $stable(low_is_rom));

    // R8
    blank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_inhibit && io_wr && (addr[7:0] == 8'hE1 || addr[7:0] == 8'hE3)) |=> top_inhibit);

    // R4
    top_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && addr[7:0] == 8'hE1) |=> (top_map == 1'b0));

    // R1
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iorq_n || wr_n) |=> ($stable(top_inhibit) && $stable(low_is_rom) && $stable(top_map)));

endmodule

bind bank_switcher bank_switcher_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .iorq_n      (iorq_n),
    .mreq_n      (mreq_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .sel_ram     (sel_ram),
    .sel_rom     (sel_rom),
    .sel_io      (sel_io),
    .top_inhibit (top_inhibit),
    .low_is_rom  (low_is_rom),
    .top_map     (top_map)
);

// File: tb/test_bank_switcher.sv
// Bench for bank_switcher: a vector table walked by one loop, then directed
// tests for strobe qualification, edge timing and reset.
module test_bank_switcher;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 37;
    localparam int WD_CYCLES  = 5000;

    // Vector word: {probe(1), req(4), addr(16), exp {ram,rom,io,inh}(4)}
    // probe=0 means a port write to addr; exp is ignored for writes.
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 4'd9,  16'h0000, 4'h4},  // R9 reset map, low ROM
        {1'b1, 4'd9,  16'h5000, 4'h8},  // R9 middle RAM
        {1'b1, 4'd9,  16'hE000, 4'h2},  // R9 top I/O
        {1'b0, 4'd3,  16'hABE0, 4'h0},  // R3 low -> RAM (upper byte junk, R1)
        {1'b1, 4'd3,  16'h0FFF, 4'h8},  // R3
        {1'b1, 4'd2,  16'h1000, 4'h8},  // R2 boundary
        {1'b0, 4'd3,  16'h12E2, 4'h0},  // R3 low -> ROM
        {1'b1, 4'd3,  16'h0800, 4'h4},  // R3
        {1'b0, 4'd4,  16'h00E1, 4'h0},  // R4 top -> RAM
        {1'b1, 4'd4,  16'hD000, 4'h8},  // R4
        {1'b0, 4'd4,  16'hFFE3, 4'h0},  // R4 top -> I/O
        {1'b1, 4'd4,  16'hFFFF, 4'h2},  // R4
        {1'b0, 4'd5,  16'h00E1, 4'h0},  // R5 setup
        {1'b0, 4'd5,  16'h00E0, 4'h0},  // R5 setup
        {1'b0, 4'd5,  16'h00E4, 4'h0},  // R5 default map
        {1'b1, 4'd5,  16'h0000, 4'h4},  // R5
        {1'b1, 4'd5,  16'hD000, 4'h2},  // R5
        {1'b0, 4'd6,  16'h00E1, 4'h0},  // R6 top RAM before blank
        {1'b0, 4'd6,  16'h00E5, 4'h0},  // R6 blank
        {1'b1, 4'd6,  16'hD000, 4'h1},  // R6 nothing selected
        {1'b1, 4'd7,  16'h0000, 4'h5},  // R7 low unchanged by blank
        {1'b1, 4'd2,  16'hCFFF, 4'h9},  // R2 middle while blanked
        {1'b0, 4'd6,  16'h00E5, 4'h0},  // R6 second blank
        {1'b1, 4'd6,  16'hF000, 4'h1},  // R6
        {1'b0, 4'd7,  16'h00E6, 4'h0},  // R7 unblank
        {1'b1, 4'd7,  16'hD000, 4'h8},  // R7 RAM restored
        {1'b0, 4'd8,  16'h00E5, 4'h0},  // R8 blank
        {1'b0, 4'd8,  16'h00E3, 4'h0},  // R8 remap while blanked
        {1'b1, 4'd8,  16'hDFFF, 4'h1},  // R8 still blanked
        {1'b0, 4'd8,  16'h00E6, 4'h0},  // R8 unblank
        {1'b1, 4'd8,  16'hD000, 4'h2},  // R8 new mapping shows
        {1'b0, 4'd7,  16'h00E0, 4'h0},  // R7 low RAM
        {1'b0, 4'd7,  16'h00E5, 4'h0},  // R7
        {1'b0, 4'd7,  16'h00E6, 4'h0},  // R7
        {1'b1, 4'd7,  16'h0100, 4'h8},  // R7 low still RAM
        {1'b0, 4'd2,  16'h00E2, 4'h0},  // R2 low back to ROM
        {1'b1, 4'd2,  16'h8000, 4'h8}   // R2
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr;
    logic        iorq_n;
    logic        mreq_n;
    logic        rd_n;
    logic        wr_n;
    logic        sel_ram;
    logic        sel_rom;
    logic        sel_io;
    logic        top_inhibit;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bank_switcher i_bank_switcher (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .iorq_n      (iorq_n),
        .mreq_n      (mreq_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .sel_ram     (sel_ram),
        .sel_rom     (sel_rom),
        .sel_io      (sel_io),
        .top_inhibit (top_inhibit)
    );

    task automatic check(input int req, input logic [3:0] exp);
        logic [3:0] got;
        got = {sel_ram, sel_rom, sel_io, top_inhibit};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d addr=%h got {ram,rom,io,inh}=%b expected %b",
                     req, addr, got, exp);
        end
    endtask

    // Port write: strobes held across one rising edge.
    task automatic port_write(input logic [15:0] a);
        @(negedge clk);
        addr   = a;
        iorq_n = 1'b0;
        wr_n   = 1'b0;
        @(negedge clk);
        iorq_n = 1'b1;
        wr_n   = 1'b1;
    endtask

    // Memory read probe, sampled between edges.
    task automatic probe(input logic [15:0] a, input int req, input logic [3:0] exp);
        addr   = a;
        mreq_n = 1'b0;
        rd_n   = 1'b0;
        #1;
        check(req, exp);
        mreq_n = 1'b1;
        rd_n   = 1'b1;
    endtask

    // Arbitrary strobe cycle across one rising edge.
    task automatic raw_cycle(input logic [15:0] a, input logic io, input logic mr,
                             input logic rd, input logic wr);
        @(negedge clk);
        addr = a; iorq_n = io; mreq_n = mr; rd_n = rd; wr_n = wr;
        @(negedge clk);
        iorq_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; addr = '0;
        iorq_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][24]) begin
                probe(VEC[i][19:4], int'(VEC[i][23:20]), VEC[i][3:0]);
            end else begin
                port_write(VEC[i][19:4]);
            end
        end

        // R1: I/O read of the blank port changes nothing.
        raw_cycle(16'h00E5, 1'b0, 1'b1, 1'b0, 1'b1);
        probe(16'hE000, 1, 4'h2);
        // R1: memory write to 0x00E5 is not a port write.
        raw_cycle(16'h00E5, 1'b1, 1'b0, 1'b1, 1'b0);
        probe(16'hE000, 1, 4'h2);
        // R1: writes to unused port numbers.
        port_write(16'h00E7);
        port_write(16'h00D5);
        probe(16'h0000, 1, 4'h4);
        probe(16'hD000, 1, 4'h2);

        // R10: no select without MREQ, or with MREQ but no data strobe.
        @(negedge clk);
        addr = 16'h5000; mreq_n = 1'b1; rd_n = 1'b0; #1;
        check(10, 4'h0);
        mreq_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; #1;
        check(10, 4'h0);
        wr_n = 1'b0; #1;
        check(10, 4'h8);
        mreq_n = 1'b1; wr_n = 1'b1;

        // R11: I/O write to 0xE1 overlapped with a top-region read.
        @(negedge clk);
        addr = 16'hD0E1; iorq_n = 1'b0; wr_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0;
        #1;
        check(11, 4'h2);
        @(negedge clk);
        check(11, 4'h8);
        iorq_n = 1'b1; wr_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1;

        // R9: reset from a changed map.
        port_write(16'h00E0);
        port_write(16'h00E5);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe(16'h0000, 9, 4'h4);
        probe(16'hD000, 9, 4'h2);
        probe(16'h5000, 9, 4'h8);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", WD_CYCLES);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule